// File: doc/BRIEF.md
# Four-Channel Pulse-Width DAC

This block turns four 8-bit codes into four pulse-width modulated output pins. A host writes each channel's code through a plain address/data bus and can read it back in the same cycle. After an external low-pass filter, the average level of each pin follows its code.

All channels share one free-running tick counter. Two mode inputs set how the counter runs. `fastTick` picks the tick rate. When it is 1 the counter advances on every clock. When it is 0 the counter advances on every second clock, through a clock-enable. `shortPeriod` picks the wrap length: 256 ticks when it is 0, or 253 ticks when it is 1. A pin is high while the counter is below the code that is active for the current period.

Codes are double-buffered. A write lands in the channel register at once, but the comparator only uses the new code from the start of the next period. No period ever contains a mix of two codes.

Top module: `pwmdac_top`

## Requirements
- R1: After reset every channel register reads 00h and every pin is low.
- R2: A write with `busWrEn`=1 to address 20h, 21h, 22h or 23h stores `busWrData` in channel 0, 1, 2 or 3 at the clock edge. `busRdData` shows the register selected by `busAddr` combinationally, in the same cycle.
- R3: A write to any address outside 20h..23h changes no register. A read from such an address returns 00h.
- R4: In steady state, a channel is high for min(code, period) ticks in each period. It is high while the shared counter is below the code.
- R5: The period is 256 ticks when `shortPeriod`=0 and 253 ticks when `shortPeriod`=1.
- R6: With `shortPeriod`=1, the codes FDh, FEh and FFh each give a pin that is high on every cycle.
- R7: With `shortPeriod`=0, code FFh gives a pin that is low for exactly one tick in every period.
- R8: Code 00h gives a pin that is low on every cycle, in both period modes.
- R9: A tick lasts one clock when `fastTick`=1 and two clocks when `fastTick`=0.
- R10: A code written during a period does not affect the pin until the counter next wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Run clock, at twice the base tick rate |
| rstN | input | 1 | Active-low synchronous reset |
| fastTick | input | 1 | 1: one tick per clock; 0: one tick per two clocks |
| shortPeriod | input | 1 | 1: 253-tick period; 0: 256-tick period |
| busAddr | input | 8 | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| pwmOut | output | 4 | One PWM pin per channel, bit n is channel n |

## Verification
Bus reads are combinational. The bench therefore sets the address and checks the read data a moment later, in the same clock low phase.

A write reaches the register at the next rising edge. It reaches a pin only at the next counter wrap, which can be up to 256 ticks away, or 512 clocks at the half rate. Before any duty measurement, the bench waits longer than one full period so the new code is sure to be active.

Duty is then counted over a window of exactly one period in clocks, sampled on falling edges. Any window of that length gives the same high count, whatever its phase, so no alignment to the counter is needed. For period length and deferred loading, channel 0 holds code 01h and acts as a start-of-period marker: its rising edge marks counter zero. The bench times the gap between marker edges, and watches a second channel between two marker edges.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  typedef struct packed {
    logic tick;
    logic load;
  } pwmStrobe_t;
endpackage

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SHORT_LEN = 253
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastTick,
  input  logic              shortPeriod,
  output pwmStrobe_t        strobe,
  output logic [CODE_W-1:0] cnt
);
  localparam int FULL_LEN = 1 << CODE_W;
  localparam logic [CODE_W-1:0] LAST_FULL  = CODE_W'(FULL_LEN - 1);
  localparam logic [CODE_W-1:0] LAST_SHORT = CODE_W'(SHORT_LEN - 1);

  logic              halfPhase;
  logic              tickEn;
  logic              wrapNow;
  logic [CODE_W-1:0] lastVal;

  // Half-rate enable: toggles every clock, so it is high on every second cycle.
  always_ff @(posedge clk) begin
    if (!rstN) halfPhase <= 1'b0;
    else       halfPhase <= ~halfPhase;
  end

  always_comb begin
    tickEn  = fastTick | halfPhase;
    lastVal = shortPeriod ? LAST_SHORT : LAST_FULL;
    // ">=" also covers a switch to the short period while the counter is beyond it.
    wrapNow = tickEn && (cnt >= lastVal);
    strobe.tick = tickEn;
    strobe.load = wrapNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (wrapNow) cnt <= '0;
    else if (tickEn)  cnt <= cnt + 1'b1;
  end

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.load) |=> (cnt == $past(cnt) + 1'b1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(cnt));
  p_half_rate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!fastTick && strobe.tick) |=> (fastTick || !strobe.tick));
  p_short_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && shortPeriod && cnt == LAST_SHORT) |=> (cnt == '0));
endmodule

// File: rtl/pwmdac_path.sv
module pwmdac_path
  import pwmdac_pkg::*;
#(
  parameter int              NUM_CH    = 4,
  parameter int              CODE_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [CODE_W-1:0] cnt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CODE_W-1:0] busWrData,
  output logic [CODE_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0] addrOffs;
  logic              addrHit;
  logic [SEL_W-1:0]  chSel;
  logic [CODE_W-1:0] codeReg   [NUM_CH];
  logic [CODE_W-1:0] activeReg [NUM_CH];

  always_comb begin
    addrOffs  = busAddr - BASE_ADDR;
    addrHit   = (busAddr >= BASE_ADDR) && (addrOffs < ADDR_W'(NUM_CH));
    chSel     = addrOffs[SEL_W-1:0];
    busRdData = addrHit ? codeReg[chSel] : '0;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic wrHere;
    assign wrHere = busWrEn && addrHit && (chSel == SEL_W'(ch));

    always_ff @(posedge clk) begin
      if (!rstN)       codeReg[ch] <= '0;
      else if (wrHere) codeReg[ch] <= busWrData;
    end

    // Shadow copy, refreshed only at the counter wrap.
    always_ff @(posedge clk) begin
      if (!rstN)            activeReg[ch] <= '0;
      else if (strobe.load) activeReg[ch] <= codeReg[ch];
    end

    assign pwmOut[ch] = (cnt < activeReg[ch]);

    p_active_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load |=> $stable(activeReg[ch]));
    p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !(busWrEn && addrHit) |=> $stable(codeReg[ch]));
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rstN)
      (activeReg[ch] == '0) |-> !pwmOut[ch]);
    p_load_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load |-> strobe.tick);
  end

  p_unmapped_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < BASE_ADDR) |-> (busRdData == '0));
endmodule

// File: rtl/pwmdac_top.sv
module pwmdac_top
  import pwmdac_pkg::*;
#(
  parameter int              NUM_CH    = 4,
  parameter int              CODE_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
  parameter int              SHORT_LEN = 253
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastTick,
  input  logic              shortPeriod,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CODE_W-1:0] busWrData,
  output logic [CODE_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmStrobe_t        strobe;
  logic [CODE_W-1:0] cnt;

  pwmdac_ctrl #(.CODE_W(CODE_W), .SHORT_LEN(SHORT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .shortPeriod(shortPeriod),
    .strobe(strobe), .cnt(cnt)
  );

  pwmdac_path #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pwmOut(pwmOut)
  );

  p_reset_low_r1: assert property (@(posedge clk) $fell(rstN) |=> (pwmOut == '0));
endmodule

// File: tb/sim_pwmdac_top.sv
module sim_pwmdac_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fastTick = 1'b1;
  logic       shortPeriod = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [3:0] pwmOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int hi [4];

  always #10 clk = ~clk;

  pwmdac_top u0 (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .shortPeriod(shortPeriod),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readChk(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    check(busRdData == 8'(exp), tag, int'(busRdData), exp);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < 4; c++) hi[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) hi[c] += int'(pwmOut[c]);
    end
  endtask

  // Returns at the falling edge where channel 0 has just gone high (counter zero).
  task automatic waitRise();
    logic prev;
    @(negedge clk);
    prev = pwmOut[0];
    forever begin
      @(negedge clk);
      if (pwmOut[0] && !prev) break;
      prev = pwmOut[0];
    end
  endtask

  function automatic string tagFor(input int code, input bit shortM);
    if (code == 0) return "R8";
    if (shortM && code >= 253) return "R6";
    if (!shortM && code == 255) return "R7";
    return "R4";
  endfunction

  task automatic sweepSet(input int c0, input int c1, input int c2, input int c3, input int step);
    int codes [4];
    int per;
    int exp;
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    per = shortPeriod ? 253 : 256;
    for (int c = 0; c < 4; c++) busWrite(8'h20 + 8'(c), 8'(codes[c]));
    repeat (per * step + 4) @(negedge clk);
    measure(per * step);
    for (int c = 0; c < 4; c++) begin
      exp = ((codes[c] < per) ? codes[c] : per) * step;
      check(hi[c] == exp, tagFor(codes[c], shortPeriod), hi[c], exp);
    end
  endtask

  task automatic gapChk(input int exp, input string tag);
    int n;
    waitRise();
    n = 0;
    begin
      logic prev;
      prev = 1'b1;
      forever begin
        @(negedge clk);
        n++;
        if (pwmOut[0] && !prev) break;
        prev = pwmOut[0];
      end
    end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(pwmOut == 4'h0, "R1 pins low in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    for (int c = 0; c < 4; c++) readChk(8'h20 + 8'(c), 0, "R1 reset read");
    repeat (20) @(negedge clk);
    check(pwmOut == 4'h0, "R1 pins low after reset", int'(pwmOut), 0);

    // R2 read-back, R3 unmapped accesses
    busWrite(8'h20, 8'h11); busWrite(8'h21, 8'h22);
    busWrite(8'h22, 8'h33); busWrite(8'h23, 8'h44);
    readChk(8'h20, 8'h11, "R2 ch0"); readChk(8'h21, 8'h22, "R2 ch1");
    readChk(8'h22, 8'h33, "R2 ch2"); readChk(8'h23, 8'h44, "R2 ch3");
    busWrite(8'h24, 8'h99); busWrite(8'h1F, 8'h77);
    busWrite(8'hA0, 8'h55); busWrite(8'h00, 8'h66);
    readChk(8'h20, 8'h11, "R3 ch0 kept"); readChk(8'h21, 8'h22, "R3 ch1 kept");
    readChk(8'h22, 8'h33, "R3 ch2 kept"); readChk(8'h23, 8'h44, "R3 ch3 kept");
    readChk(8'h24, 0, "R3 read 24h"); readChk(8'h1F, 0, "R3 read 1Fh");
    readChk(8'hA0, 0, "R3 read A0h");

    // Exhaustive code sweep at full rate, both period modes
    fastTick = 1'b1;
    for (int m = 0; m < 2; m++) begin
      shortPeriod = (m == 1);
      repeat (600) @(negedge clk);
      for (int k = 0; k < 64; k++) sweepSet(4*k, 4*k+1, 4*k+2, 4*k+3, 1);
    end

    // Half rate, R9
    fastTick = 1'b0;
    for (int m = 0; m < 2; m++) begin
      shortPeriod = (m == 1);
      repeat (1100) @(negedge clk);
      sweepSet(0, 100, 255, 3, 2);
      sweepSet(128, 254, 1, 253, 2);
    end

    // R5 / R9 period length via marker channel 0 = 01h
    busWrite(8'h20, 8'h01);
    fastTick = 1'b0; shortPeriod = 1'b0;
    repeat (1100) @(negedge clk);
    gapChk(512, "R9 half-rate period");
    fastTick = 1'b1; shortPeriod = 1'b1;
    repeat (600) @(negedge clk);
    gapChk(253, "R5 short period");
    shortPeriod = 1'b0;
    repeat (600) @(negedge clk);
    gapChk(256, "R5 full period");

    // R10: write mid-period, no effect until next wrap
    busWrite(8'h21, 8'd10);
    repeat (600) @(negedge clk);
    waitRise();
    repeat (50) @(negedge clk);
    busWrite(8'h21, 8'd200);
    n = 0;
    begin
      logic prev;
      prev = pwmOut[0];
      forever begin
        @(negedge clk);
        if (pwmOut[0] && !prev) break;
        prev = pwmOut[0];
        n += int'(pwmOut[1]);
      end
    end
    check(n == 0, "R10 old code kept to wrap", n, 0);
    measure(256);
    check(hi[1] == 200, "R10 new code after wrap", hi[1], 200);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule